// File: doc/BRIEF.md
# Packed Lane Unpack-Interleave Unit

This unit performs a 128-bit unpack-and-interleave. It takes a destination vector and a source vector and builds the result by alternating their lanes, always starting with a destination lane. There are four operations. Two use 32-bit lanes and two use 64-bit lanes. Each takes either the low half or the high half of both operands. The operation is a pure data move, so no arithmetic flags or floating-point exceptions are produced.

Before the result is committed, a set of fault checks is evaluated in priority order. The checks use the control state: the emulation bit, the task-switched bit, the OS extended-state support bit, the two feature-present bits and the locked-prefix flag. For a memory source, the 16-byte alignment of its address is also checked. When any check fails, the highest-priority fault code is output, the result register keeps its old value and no valid result is produced. Otherwise the result is registered one cycle after the request.

Top module: `lane_unpack_unit`

## Requirements
- R1: Operation code 2'b00 (32-bit low) gives result lanes 0..3 equal to dst lane 0, src lane 0, dst lane 1, src lane 1. Lane k occupies bits 32k+31:32k.
- R2: Operation code 2'b01 (32-bit high) gives result lanes 0..3 equal to dst lane 2, src lane 2, dst lane 3, src lane 3.
- R3: Operation code 2'b10 (64-bit low) gives result[63:0]=dst[63:0] and result[127:64]=src[63:0].
- R4: Operation code 2'b11 (64-bit high) gives result[63:0]=dst[127:64] and result[127:64]=src[127:64].
- R5: After a fault-free request in cycle N, out_valid is 1 and the result is presented in cycle N+1. Without a request, out_valid is 0 in the next cycle.
- R6: An invalid-opcode fault (code 3'd1) is raised when any of these hold:
  - the emulation bit is 1;
  - the OS support bit is 0;
  - the locked-prefix flag is 1;
  - the feature bit for the operation is 0 (the single-precision feature bit for codes 00/01, the double-precision feature bit for codes 10/11).
- R7: A device-unavailable fault (code 3'd2) is raised when the task-switched bit is 1 and no invalid-opcode condition holds.
- R8: An alignment fault (code 3'd3) is raised when the source is from memory, the address bits [3:0] are not all zero, and no higher-priority fault holds. A register source ignores the address.
- R9: A faulted request gives out_valid=0 and fault_valid=1 with the code in the next cycle. The result output keeps its previous value.
- R10: After reset, out_valid=0, fault_valid=0, fault_code=0 and result=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation code |
| dst_vec | input | 128 | Destination operand |
| src_vec | input | 128 | Source operand |
| src_is_mem | input | 1 | Source came from memory |
| src_addr | input | 64 | Memory source address |
| ctl_emulate | input | 1 | Emulation control bit |
| ctl_task_sw | input | 1 | Task-switched control bit |
| ctl_os_xsave | input | 1 | OS extended-state support bit |
| feat_sp | input | 1 | Single-precision vector feature present |
| feat_dp | input | 1 | Double-precision vector feature present |
| lock_pfx | input | 1 | Locked prefix present |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |
| fault_valid | output | 1 | Fault raised |
| fault_code | output | 3 | Fault code: 1 invalid-opcode, 2 device-unavailable, 3 alignment |

## Verification
The assertions check these properties on every cycle:
- out_valid and fault_valid are never both high.
- Each output strobe follows a request by one cycle.
- The result holds steady across faulted and idle cycles.
- A reported fault code is always a legal, nonzero value.

Only the bench's scenarios can show that each lane map picks the correct lanes. The same holds for fault priority under overlapping conditions, and for ignoring the address when the source is a register. These are covered by random operands and fault inputs compared against the bench's reference functions, plus directed corner cases.

// File: rtl/lane_unpack_pkg.sv
package lane_unpack_pkg;
  localparam int VEC_W  = 128;
  localparam int ADDR_W = 64;
  localparam int ALIGN_BYTES = 16;
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  typedef enum logic [1:0] {
    OP_LO32 = 2'b00,
    OP_HI32 = 2'b01,
    OP_LO64 = 2'b10,
    OP_HI64 = 2'b11
  } unpack_op_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_INVOP = 3'd1,
    FLT_DEVNA = 3'd2,
    FLT_ALIGN = 3'd3
  } fault_e;
endpackage

// File: rtl/lane_interleave.sv
module lane_interleave
  import lane_unpack_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  unpack_op_e   op,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  output logic [W-1:0] mixed
);
  localparam int NARROW = 32;
  localparam int WIDE   = 64;
  localparam int NL     = W / NARROW;
  localparam int WL     = W / WIDE;
  localparam int NHALF  = NL / 2;
  localparam int WHALF  = WL / 2;

  logic [W-1:0] lo32, hi32, lo64, hi64;

  // Output lane 2k comes from dst, lane 2k+1 from src, both taken from the selected half.
  for (genvar k = 0; k < NHALF; k++) begin : g_narrow
    assign lo32[(2*k)*NARROW   +: NARROW] = dst[k*NARROW +: NARROW];
    assign lo32[(2*k+1)*NARROW +: NARROW] = src[k*NARROW +: NARROW];
    assign hi32[(2*k)*NARROW   +: NARROW] = dst[(k+NHALF)*NARROW +: NARROW];
    assign hi32[(2*k+1)*NARROW +: NARROW] = src[(k+NHALF)*NARROW +: NARROW];
  end

  for (genvar k = 0; k < WHALF; k++) begin : g_wide
    assign lo64[(2*k)*WIDE   +: WIDE] = dst[k*WIDE +: WIDE];
    assign lo64[(2*k+1)*WIDE +: WIDE] = src[k*WIDE +: WIDE];
    assign hi64[(2*k)*WIDE   +: WIDE] = dst[(k+WHALF)*WIDE +: WIDE];
    assign hi64[(2*k+1)*WIDE +: WIDE] = src[(k+WHALF)*WIDE +: WIDE];
  end

  always_comb begin
    unique case (op)
      OP_LO32: mixed = lo32;
      OP_HI32: mixed = hi32;
      OP_LO64: mixed = lo64;
      default: mixed = hi64;
    endcase
  end
endmodule

// File: rtl/fault_prio.sv
module fault_prio
  import lane_unpack_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  unpack_op_e    op,
  input  logic          src_is_mem,
  input  logic [AW-1:0] src_addr,
  input  logic          ctl_emulate,
  input  logic          ctl_task_sw,
  input  logic          ctl_os_xsave,
  input  logic          feat_sp,
  input  logic          feat_dp,
  input  logic          lock_pfx,
  output fault_e        fault
);
  logic feat_ok, invop, devna, misal;

  assign feat_ok = (op == OP_LO32 || op == OP_HI32) ? feat_sp : feat_dp;
  assign invop   = ctl_emulate | ~ctl_os_xsave | ~feat_ok | lock_pfx;
  assign devna   = ctl_task_sw;
  assign misal   = src_is_mem & (|src_addr[ALIGN_LSB-1:0]);

  always_comb begin
    if (invop)      fault = FLT_INVOP;
    else if (devna) fault = FLT_DEVNA;
    else if (misal) fault = FLT_ALIGN;
    else            fault = FLT_NONE;
  end
endmodule

// File: rtl/lane_unpack_unit.sv
module lane_unpack_unit
  import lane_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [VEC_W-1:0]  dst_vec,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic              src_is_mem,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              ctl_emulate,
  input  logic              ctl_task_sw,
  input  logic              ctl_os_xsave,
  input  logic              feat_sp,
  input  logic              feat_dp,
  input  logic              lock_pfx,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic              fault_valid,
  output logic [2:0]        fault_code
);
  unpack_op_e       op;
  logic [VEC_W-1:0] mixed;
  fault_e           fault;

  logic             rst_sync_q, rst_n_int;
  logic             res_en, flt_en;
  logic             out_valid_d, fault_valid_d;
  logic [2:0]       fault_code_d;

  assign op = unpack_op_e'(op_sel);

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_sync_q <= 1'b1;
      rst_n_int  <= rst_sync_q;
    end
  end

  lane_interleave #(.W(VEC_W)) u_mix (
    .op(op), .dst(dst_vec), .src(src_vec), .mixed(mixed)
  );

  fault_prio #(.AW(ADDR_W)) u_flt (
    .op(op), .src_is_mem(src_is_mem), .src_addr(src_addr),
    .ctl_emulate(ctl_emulate), .ctl_task_sw(ctl_task_sw),
    .ctl_os_xsave(ctl_os_xsave), .feat_sp(feat_sp), .feat_dp(feat_dp),
    .lock_pfx(lock_pfx), .fault(fault)
  );

  always_comb begin
    res_en        = in_valid && (fault == FLT_NONE);
    flt_en        = in_valid && (fault != FLT_NONE);
    out_valid_d   = res_en;
    fault_valid_d = flt_en;
    fault_code_d  = flt_en ? fault : fault_code;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid   <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= 3'd0;
    end else begin
      out_valid   <= out_valid_d;
      fault_valid <= fault_valid_d;
      fault_code  <= fault_code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  result <= '0;
    else if (res_en) result <= mixed;
  end

  AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(out_valid && fault_valid)); // R9
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> !out_valid && !fault_valid); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    !out_valid |-> $stable(result) || $past(!rst_n_int)); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_int)
    fault_valid |-> (fault_code >= 3'd1 && fault_code <= 3'd3)); // R6
  AST_LOCK_INVOP: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_valid && lock_pfx |=> fault_valid && fault_code == 3'd1); // R6
  AST_TS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_valid && ctl_task_sw |=> fault_valid && fault_code != 3'd3); // R7
endmodule

// File: tb/lane_unpack_unit_tb_top.sv
module lane_unpack_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [1:0] op_sel;
  logic [127:0] dst_vec, src_vec;
  logic src_is_mem;
  logic [63:0] src_addr;
  logic ctl_emulate, ctl_task_sw, ctl_os_xsave, feat_sp, feat_dp, lock_pfx;
  logic out_valid, fault_valid;
  logic [127:0] result;
  logic [2:0] fault_code;

  int checks = 0, fails = 0;
  logic [127:0] last_res;

  always #5 clk = ~clk;

  lane_unpack_unit dut_i (.*);

  function automatic logic [127:0] ref_mix(input logic [1:0] op, input logic [127:0] d, input logic [127:0] s);
    case (op)
      2'b00: return {s[63:32], d[63:32], s[31:0], d[31:0]};    // R1
      2'b01: return {s[127:96], d[127:96], s[95:64], d[95:64]}; // R2
      2'b10: return {s[63:0], d[63:0]};                       // R3
      default: return {s[127:64], d[127:64]};                 // R4
    endcase
  endfunction

  function automatic logic [2:0] ref_fault(input logic [1:0] op, input logic mem, input logic [63:0] a,
      input logic em, input logic ts, input logic os, input logic fs, input logic fd, input logic lk);
    logic f;
    f = op[1] ? fd : fs;
    if (em || !os || !f || lk) return 3'd1; // R6
    if (ts) return 3'd2;                    // R7
    if (mem && a[3:0] != 4'd0) return 3'd3; // R8
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ctl();
    ctl_emulate = 0; ctl_task_sw = 0; ctl_os_xsave = 1; feat_sp = 1; feat_dp = 1; lock_pfx = 0;
    src_is_mem = 0; src_addr = '0;
  endtask

  // Drive one request after a falling edge, then sample at the next falling edge.
  task automatic issue(input string tag, input logic [1:0] op, input logic [127:0] d, input logic [127:0] s);
    logic [2:0] ef;
    logic [127:0] er;
    @(negedge clk);
    in_valid = 1; op_sel = op; dst_vec = d; src_vec = s;
    ef = ref_fault(op, src_is_mem, src_addr, ctl_emulate, ctl_task_sw, ctl_os_xsave, feat_sp, feat_dp, lock_pfx);
    er = (ef == 3'd0) ? ref_mix(op, d, s) : last_res;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " out_valid R5"}, {127'd0, out_valid}, {127'd0, ef == 3'd0});
    chk({tag, " fault_valid R9"}, {127'd0, fault_valid}, {127'd0, ef != 3'd0});
    if (ef != 3'd0) chk({tag, " fault_code R6/R7/R8"}, {125'd0, fault_code}, {125'd0, ef});
    chk({tag, " result R1..R4/R9"}, result, er);
    last_res = er;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog R5 actual=hang expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] d, s;
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; op_sel = 0; dst_vec = 0; src_vec = 0; clear_ctl();
    last_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10
    chk("reset out_valid R10", {127'd0, out_valid}, 128'd0);
    chk("reset fault_valid R10", {127'd0, fault_valid}, 128'd0);
    chk("reset fault_code R10", {125'd0, fault_code}, 128'd0);
    chk("reset result R10", result, 128'd0);

    d = 128'h33333333_22222222_11111111_00000000;
    s = 128'hBBBBBBBB_AAAAAAAA_99999999_88888888;
    issue("R1 lo32", 2'b00, d, s);
    issue("R2 hi32", 2'b01, d, s);
    issue("R3 lo64", 2'b10, d, s);
    issue("R4 hi64", 2'b11, d, s);
    // R5: idle cycle
    @(negedge clk);
    chk("idle out_valid R5", {127'd0, out_valid}, 128'd0);
    chk("idle result hold R5", result, last_res);

    // Directed fault corners
    lock_pfx = 1; ctl_task_sw = 1; src_is_mem = 1; src_addr = 64'h4;
    issue("R6 lock over ts/align", 2'b00, ~d, ~s); clear_ctl();
    feat_sp = 0; issue("R6 no sp feature", 2'b01, ~d, s); clear_ctl();
    feat_sp = 0; issue("R6 sp ignored for 64-bit", 2'b10, d, ~s); clear_ctl();
    feat_dp = 0; issue("R6 no dp feature", 2'b11, d, s); clear_ctl();
    ctl_os_xsave = 0; issue("R6 os bit clear", 2'b00, d, s); clear_ctl();
    ctl_emulate = 1; issue("R6 emulate", 2'b00, d, s); clear_ctl();
    ctl_task_sw = 1; src_is_mem = 1; src_addr = 64'h8;
    issue("R7 ts over align", 2'b01, d, s); clear_ctl();
    src_is_mem = 1; src_addr = 64'h1001; issue("R8 misaligned", 2'b10, s, d); clear_ctl();
    src_is_mem = 1; src_addr = 64'hF0; issue("R8 aligned mem", 2'b11, s, d); clear_ctl();
    src_is_mem = 0; src_addr = 64'h7; issue("R8 reg ignores addr", 2'b00, s, d); clear_ctl();

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      op = 2'($urandom);
      d = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      ctl_emulate  = ($urandom % 10) == 0;
      ctl_task_sw  = ($urandom % 8) == 0;
      ctl_os_xsave = ($urandom % 10) != 0;
      feat_sp      = ($urandom % 10) != 0;
      feat_dp      = ($urandom % 10) != 0;
      lock_pfx     = ($urandom % 12) == 0;
      src_is_mem   = $urandom % 2;
      src_addr     = {$urandom, $urandom} & (($urandom % 2) ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'hFFFF_FFFF_FFFF_FFFF);
      issue("rand R1..R9", op, d, s);
    end
    clear_ctl();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule